// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block sends one low-speed USB packet on the D+ and D- lines each time it is started. It first drives the idle level (J) with the driver still off. It then turns the driver on and holds J for one bit time. After that it sends the sync byte and the packet bytes, least-significant bit first. The bit stream is bit-stuffed and NRZI-coded. The packet closes with an end-of-packet sequence, after which the block releases the lines.

A start pulse picks the packet kind. A data packet draws a given number of bytes from a ready/valid byte source. A handshake packet sends one PID byte given with the start pulse. The block also holds a pending device address. That address becomes the active address only when a data packet reaches its end-of-packet, never after a handshake.

Top module: `usb_ls_tx`

## Requirements
- R1: Out of reset and whenever `busy` is low, `usb_oe`, `usb_dp` and `usb_dm` are all low.
- R2: The clock edge that samples `start` while idle raises `busy` and drives J (`usb_dp`=0, `usb_dm`=1) for one clock with `usb_oe` low. `usb_oe` then rises and J is held for one bit time before the first packet bit.
- R3: Every line symbol (lead-in J, packet bit, stuffed bit, end-of-packet part) lasts BIT_CLKS clocks, 8 by default.
- R4: The first byte sent is the sync byte 0x80, sent LSB first. The packet bytes follow in order of arrival, each LSB first.
- R5: NRZI coding: a 0 bit switches the line between J ({dp,dm}=01) and K ({dp,dm}=10), and a 1 bit keeps the level.
- R6: After STUFF_RUN (6) consecutive 1 bits, an extra line transition is inserted and the run restarts. The run is counted across byte boundaries, and a stuffed transition is still sent after the last bit.
- R7: After the last bit the block drives SE0 (both lines low, `usb_oe` high) for 2 bit times, then J for 1 bit time. On the next clock `usb_oe`, `usb_dp`, `usb_dm` and `busy` are low and `done` is high for exactly one clock.
- R8: With `hs_mode`=1 the packet is the sync byte followed by `hs_pid` alone, and `in_ready` stays low for the whole packet.
- R9: With `hs_mode`=0 exactly `byte_count` bytes are taken through `in_valid`/`in_ready`. A count of 0 sends the sync byte alone.
- R10: `addr_wr` stores `addr_in` as pending. The pending value moves to `dev_addr` when a data packet enters SE0. A handshake packet leaves both `dev_addr` and the pending value unchanged.
- R11: A `start` pulse while `busy` is high has no effect on the packet in flight and does not start a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 12 MHz nominal |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a packet (sampled when idle) |
| hs_mode | input | 1 | 1: handshake packet, 0: data packet |
| hs_pid | input | 8 | PID byte for a handshake packet |
| byte_count | input | CNT_W | Number of data bytes after the sync byte |
| in_data | input | 8 | Data byte from the source |
| in_valid | input | 1 | Source has a byte |
| in_ready | output | 1 | Block accepts a byte this clock |
| addr_wr | input | 1 | Store a new pending device address |
| addr_in | input | ADDR_W | New device address |
| dev_addr | output | ADDR_W | Active device address |
| usb_dp | output | 1 | D+ line drive level |
| usb_dm | output | 1 | D- line drive level |
| usb_oe | output | 1 | Line driver enable |
| busy | output | 1 | High from start until the lines are released |
| done | output | 1 | One-clock pulse when a packet has finished |

## Verification
The bench targets runs of ones across a byte boundary and a run that ends on the last bit of a packet. A design that reset the run counter per byte, or skipped the final stuffed bit, would put a transition in the wrong place or drop one. It also sends an empty data packet and both handshake PIDs; a design that fetched a byte for a handshake would show `in_ready` high. Address commits are checked across a handshake that falls between two data packets, which catches a commit after the handshake or a lost pending value. A start pulse in the middle of a packet must not change or restart it.

// File: rtl/usb_ls_tx_pkg.sv
package usb_ls_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_PREP = 3'd1,
      ST_LEAD = 3'd2,
      ST_BITS = 3'd3,
      ST_SE0  = 3'd4,
      ST_EOPJ = 3'd5
   } tx_state_t;

   localparam logic [7:0] SYNC_BYTE = 8'h80;

endpackage

// File: rtl/usb_ls_tx_timer.sv
module usb_ls_tx_timer #(
   parameter int BIT_CLKS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
   localparam logic [CW-1:0] LAST = CW'(BIT_CLKS - 1);

   logic [CW-1:0] cnt;

   generate
      if (BIT_CLKS < 2) begin : g_bad_len
         $error("usb_ls_tx_timer: BIT_CLKS must be at least 2");
      end
      if ((1 << CW) == BIT_CLKS) begin : g_pow2
         always_ff @(posedge clk) begin
            if (!rst_n || !run) cnt <= '0;
            else                cnt <= cnt + 1'b1;
         end
      end else begin : g_cmp
         always_ff @(posedge clk) begin
            if (!rst_n || !run)  cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                 cnt <= cnt + 1'b1;
         end
      end
   endgenerate

   assign tick = run && (cnt == LAST);

   assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/usb_ls_tx_nrzi.sv
module usb_ls_tx_nrzi #(
   parameter int STUFF_RUN = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic emit,
   input  logic data_bit,
   output logic level,
   output logic stuff_due
);
   localparam int OW = $clog2(STUFF_RUN + 1);

   logic [OW-1:0] ones;

   generate
      if (STUFF_RUN < 1) begin : g_bad_run
         $error("usb_ls_tx_nrzi: STUFF_RUN must be at least 1");
      end
   endgenerate

   assign stuff_due = (ones == OW'(STUFF_RUN));

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         ones  <= '0;
         level <= 1'b0;
      end else if (emit) begin
         if (stuff_due || !data_bit) begin
            level <= ~level;
            ones  <= '0;
         end else begin
            ones <= ones + 1'b1;
         end
      end
   end

   // R6: a due stuffed bit is a transition and clears the run
   assert_stuff_toggles_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (emit && stuff_due && !clr) |=> (level != $past(level)) && !stuff_due);

endmodule

// File: rtl/usb_ls_tx_feed.sv
module usb_ls_tx_feed #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             hs_mode,
   input  logic [7:0]       hs_pid,
   input  logic [CNT_W-1:0] count,
   input  logic             active,
   input  logic             consume,
   input  logic [7:0]       in_data,
   input  logic             in_valid,
   output logic             in_ready,
   output logic             cur_bit,
   output logic             have_bit
);
   import usb_ls_tx_pkg::*;

   logic [7:0]       sh;
   logic [3:0]       nb;
   logic [7:0]       nxt;
   logic             nxt_full;
   logic [CNT_W-1:0] left;
   logic             accept;

   assign in_ready = active && !nxt_full && (left != '0);
   assign accept   = in_ready && in_valid;
   assign cur_bit  = sh[0];
   assign have_bit = (nb != 4'd0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh       <= '0;
         nb       <= '0;
         nxt      <= '0;
         nxt_full <= 1'b0;
         left     <= '0;
      end else if (load) begin
         sh       <= SYNC_BYTE;
         nb       <= 4'd8;
         nxt      <= hs_pid;
         nxt_full <= hs_mode;
         left     <= hs_mode ? '0 : count;
      end else begin
         if (consume) begin
            if (nb == 4'd1 && nxt_full) begin
               sh       <= nxt;
               nb       <= 4'd8;
               nxt_full <= 1'b0;
            end else begin
               sh <= {1'b0, sh[7:1]};
               nb <= nb - 4'd1;
            end
         end
         if (accept) begin
            nxt      <= in_data;
            nxt_full <= 1'b1;
            left     <= left - 1'b1;
         end
      end
   end

   // R4: the sequencer never takes a bit from an empty shifter
   assert_no_empty_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
      consume |-> have_bit);

endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx #(
   parameter int BIT_CLKS  = 8,
   parameter int STUFF_RUN = 6,
   parameter int SE0_BITS  = 2,
   parameter int CNT_W     = 6,
   parameter int ADDR_W    = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              hs_mode,
   input  logic [7:0]        hs_pid,
   input  logic [CNT_W-1:0]  byte_count,
   input  logic [7:0]        in_data,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              addr_wr,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] dev_addr,
   output logic              usb_dp,
   output logic              usb_dm,
   output logic              usb_oe,
   output logic              busy,
   output logic              done
);
   import usb_ls_tx_pkg::*;

   localparam int SW = (SE0_BITS > 1) ? $clog2(SE0_BITS) : 1;

   generate
      if (SE0_BITS < 1) begin : g_bad_se0
         $error("usb_ls_tx: SE0_BITS must be at least 1");
      end
   endgenerate

   tx_state_t         st;
   logic              hs_q;
   logic [SW-1:0]     se0_cnt;
   logic [ADDR_W-1:0] pend;
   logic              pend_v;
   logic              tick, run, level, stuff_due, cur_bit, have_bit;
   logic              take_start, emit, consume, end_bits, feeding;

   assign take_start = (st == ST_IDLE) && start;
   assign run        = (st == ST_LEAD) || (st == ST_BITS) || (st == ST_SE0) || (st == ST_EOPJ);
   assign feeding    = (st == ST_PREP) || (st == ST_LEAD) || (st == ST_BITS);
   assign emit       = tick && ((st == ST_LEAD) || (st == ST_BITS)) && (stuff_due || have_bit);
   assign consume    = emit && !stuff_due;
   assign end_bits   = tick && (st == ST_BITS) && !stuff_due && !have_bit;

   usb_ls_tx_timer #(.BIT_CLKS(BIT_CLKS)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick));

   usb_ls_tx_nrzi #(.STUFF_RUN(STUFF_RUN)) u_nrzi (
      .clk(clk), .rst_n(rst_n), .clr(take_start), .emit(emit),
      .data_bit(cur_bit), .level(level), .stuff_due(stuff_due));

   usb_ls_tx_feed #(.CNT_W(CNT_W)) u_feed (
      .clk(clk), .rst_n(rst_n), .load(take_start), .hs_mode(hs_mode),
      .hs_pid(hs_pid), .count(byte_count), .active(feeding), .consume(consume),
      .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
      .cur_bit(cur_bit), .have_bit(have_bit));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         hs_q     <= 1'b0;
         se0_cnt  <= '0;
         pend     <= '0;
         pend_v   <= 1'b0;
         dev_addr <= '0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            ST_IDLE: if (take_start) begin
               st   <= ST_PREP;
               hs_q <= hs_mode;
            end
            ST_PREP: st <= ST_LEAD;
            ST_LEAD: if (tick) st <= ST_BITS;
            ST_BITS: if (end_bits) begin
               st      <= ST_SE0;
               se0_cnt <= '0;
               if (!hs_q && pend_v) begin
                  dev_addr <= pend;
                  pend_v   <= 1'b0;
               end
            end
            ST_SE0: if (tick) begin
               if (se0_cnt == SW'(SE0_BITS - 1)) st <= ST_EOPJ;
               else se0_cnt <= se0_cnt + 1'b1;
            end
            ST_EOPJ: if (tick) begin
               st   <= ST_IDLE;
               done <= 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
         if (addr_wr) begin
            pend   <= addr_in;
            pend_v <= 1'b1;
         end
      end
   end

   always_comb begin
      usb_dp = 1'b0;
      usb_dm = 1'b0;
      usb_oe = 1'b0;
      case (st)
         ST_PREP: usb_dm = 1'b1;
         ST_LEAD: begin usb_dm = 1'b1; usb_oe = 1'b1; end
         ST_BITS: begin usb_dp = level; usb_dm = ~level; usb_oe = 1'b1; end
         ST_SE0:  usb_oe = 1'b1;
         ST_EOPJ: begin usb_dm = 1'b1; usb_oe = 1'b1; end
         default: ;
      endcase
   end

   assign busy = (st != ST_IDLE);

   assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!usb_oe && !usb_dp && !usb_dm));

   assert_bus_take_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (!usb_oe && !usb_dp && usb_dm));

   assert_no_both_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      usb_oe |-> !(usb_dp && usb_dm));

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_hs_no_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && hs_q) |-> !in_ready);

   assert_addr_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_addr != $past(dev_addr)) |-> ($past(st) == ST_BITS && !$past(hs_q)));

endmodule

// File: tb/usb_ls_tx_test.sv
module usb_ls_tx_test;
   localparam int CNT_W = 6;
   localparam int AW    = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic hs_mode = 1'b0;
   logic [7:0] hs_pid = 8'h00;
   logic [CNT_W-1:0] byte_count = '0;
   logic [7:0] in_data = 8'h00;
   logic in_valid = 1'b0;
   logic in_ready;
   logic addr_wr = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic [AW-1:0] dev_addr;
   logic usb_dp, usb_dm, usb_oe, busy, done;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   logic [7:0] pkt [0:15];
   int pkt_len = 0;
   int idx = 0;
   int acc = 0;
   logic [1:0] exp_sym [0:199];
   int exp_n = 0;

   usb_ls_tx uut (
      .clk(clk), .rst_n(rst_n), .start(start), .hs_mode(hs_mode), .hs_pid(hs_pid),
      .byte_count(byte_count), .in_data(in_data), .in_valid(in_valid),
      .in_ready(in_ready), .addr_wr(addr_wr), .addr_in(addr_in), .dev_addr(dev_addr),
      .usb_dp(usb_dp), .usb_dm(usb_dm), .usb_oe(usb_oe), .busy(busy), .done(done));

   always #5 clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   // byte source
   initial begin
      forever begin
         bit will;
         @(negedge clk);
         if (idx < pkt_len) begin
            in_data  = pkt[idx];
            in_valid = 1'b1;
         end else begin
            in_valid = 1'b0;
         end
         will = in_valid && in_ready;
         @(posedge clk);
         if (will) begin
            idx++;
            acc++;
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
      finish_run();
   end

   function automatic void push(input logic [1:0] s);
      exp_sym[exp_n] = s;
      exp_n++;
   endfunction

   // expected line symbols: lead J, coded bits (R4 R5 R6), EOP (R7)
   function automatic void build(input bit hs, input logic [7:0] pid, input int n);
      int ones = 0;
      bit lvl = 0;
      exp_n = 0;
      push(2'b01);
      for (int k = 0; k < 1 + (hs ? 1 : n); k++) begin
         logic [7:0] v;
         v = (k == 0) ? 8'h80 : (hs ? pid : pkt[k-1]);
         for (int j = 0; j < 8; j++) begin
            if (!v[j]) begin lvl = ~lvl; ones = 0; end
            else ones++;
            push(lvl ? 2'b10 : 2'b01);
            if (ones == 6) begin
               lvl = ~lvl;
               ones = 0;
               push(lvl ? 2'b10 : 2'b01);
            end
         end
      end
      push(2'b00);
      push(2'b00);
      push(2'b01);
   endfunction

   task automatic send_pkt(input bit hs, input logic [7:0] pid, input int n, input bit glitch);
      int bad = 0;
      int first_bad = -1;
      int rdy_hs = 0;
      @(negedge clk);
      idx = 0;
      acc = 0;
      pkt_len = hs ? 2 : n;
      build(hs, pid, n);
      hs_mode = hs;
      hs_pid = pid;
      byte_count = CNT_W'(n);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      chk({usb_dp, usb_dm, usb_oe, busy} == 4'b0101, "R2 prep J with driver off",
          {usb_dp, usb_dm, usb_oe, busy}, 4'b0101);
      @(posedge clk);
      for (int i = 0; i < exp_n; i++) begin
         repeat (4) @(posedge clk);
         @(negedge clk);
         if ({usb_dp, usb_dm} != exp_sym[i] || !usb_oe || !busy) begin
            bad++;
            if (first_bad < 0) first_bad = i;
         end
         if (hs && in_ready) rdy_hs++;
         if (glitch && i == 5) begin
            start = 1'b1;
            @(posedge clk);
            #1 start = 1'b0;
            repeat (3) @(posedge clk);
         end else begin
            repeat (4) @(posedge clk);
         end
      end
      chk(bad == 0, glitch ? "R11 R3 R4 R5 R6 line symbols" : "R3 R4 R5 R6 line symbols",
          first_bad, -1);
      @(negedge clk);
      chk({done, busy, usb_oe, usb_dp, usb_dm} == 5'b10000, "R7 release and done",
          {done, busy, usb_oe, usb_dp, usb_dm}, 5'b10000);
      if (hs) chk(acc == 0 && rdy_hs == 0, "R8 no byte fetch on handshake", acc + rdy_hs, 0);
      else    chk(acc == n, "R9 byte count taken", acc, n);
      @(negedge clk);
      chk({done, busy, usb_oe} == 3'b000, "R7 R11 done single and idle",
          {done, busy, usb_oe}, 3'b000);
   endtask

   task automatic write_addr(input logic [AW-1:0] a);
      @(negedge clk);
      addr_in = a;
      addr_wr = 1'b1;
      @(negedge clk);
      addr_wr = 1'b0;
   endtask

   initial begin
      void'($urandom(32'h1234_5EED));
      repeat (3) @(negedge clk);
      chk({usb_oe, usb_dp, usb_dm, busy, done} == 5'b0, "R1 reset state",
          {usb_oe, usb_dp, usb_dm, busy, done}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk({usb_oe, usb_dp, usb_dm, busy, in_ready} == 5'b0 && dev_addr == 0,
          "R1 idle after reset", {usb_oe, usb_dp, usb_dm, busy, in_ready}, 0);

      // R6: ones across a byte boundary
      pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'h01;
      send_pkt(0, 8'h00, 3, 0);
      // R6: run of ones ending on the last bit
      pkt[0] = 8'hFC;
      send_pkt(0, 8'h00, 1, 0);
      // R9: empty data packet
      send_pkt(0, 8'h00, 0, 0);
      // R8: handshakes
      pkt[0] = 8'hAA; pkt[1] = 8'h55;
      send_pkt(1, 8'hD2, 0, 0);
      send_pkt(1, 8'h5A, 0, 0);

      // R10: commit on data packet, not on handshake
      write_addr(7'h2B);
      chk(dev_addr == 7'h00, "R10 pending not active yet", dev_addr, 7'h00);
      pkt[0] = 8'h3C;
      send_pkt(0, 8'h00, 1, 0);
      chk(dev_addr == 7'h2B, "R10 commit after data packet", dev_addr, 7'h2B);
      write_addr(7'h51);
      pkt[0] = 8'h00; pkt[1] = 8'h00;
      send_pkt(1, 8'hD2, 0, 0);
      chk(dev_addr == 7'h2B, "R10 handshake leaves address", dev_addr, 7'h2B);
      send_pkt(0, 8'h00, 0, 0);
      chk(dev_addr == 7'h51, "R10 pending kept over handshake", dev_addr, 7'h51);

      // R11: start while busy is ignored
      pkt[0] = 8'h7E; pkt[1] = 8'h81;
      send_pkt(0, 8'h00, 2, 1);
      repeat (3) @(negedge clk);
      chk({busy, usb_oe} == 2'b00, "R11 no second packet", {busy, usb_oe}, 0);

      // random data packets
      for (int r = 0; r < 10; r++) begin
         int n;
         n = int'($urandom_range(0, 8));
         for (int b = 0; b < n; b++) begin
            pkt[b] = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom);
         end
         send_pkt(0, 8'h00, n, 0);
      end
      finish_run();
   end
endmodule